// File: doc/BRIEF.md
# Frame-Group Reliability Tracker

This block keeps the sender-side reliability state for one outgoing message that is cut into numbered frames. The frames are grouped into fixed-size collections. A collection is acknowledged as a whole, and it is retransmitted as a whole. Software starts a message by giving the frame count, the collection size and a timeout. The transmit path then reports each frame it puts on the wire, and the receive path reports each acknowledgement frame number it sees.

Each collection has its own timer. The timer starts once every frame of that collection has gone out, in any order. It counts tick pulses. When a timer runs out, the block requests a retransmission of the collection, naming its first and last frame, and the timer begins counting again. A collection is done when an acknowledgement names its last frame. When every collection is done, the message-done flag rises.

Top module: `frx_tracker`

## Requirements
- R1: Reset and `start` clear all state. After either, `rtx_valid` is 0. After a `start` with a non-zero frame count, `msg_done` is 0 until acknowledgements arrive. Frame and acknowledgement inputs in the `start` cycle are ignored.
- R2: With frame count N and collection size G, collection c covers frames c*G through min(c*G+G, N)-1. The final collection may therefore be short, and its retransmission request names N-1 as its last frame.
- R3: A collection's timer is loaded from `timeout_val` on the clock edge that records the last of its frames still unsent, whatever order the frames arrive in. A collection with any frame unsent never requests retransmission.
- R4: A timer counts `tick` cycles after the edge that loaded it. On the T-th tick with no acknowledgement, it requests retransmission and reloads T, so the request repeats every T ticks. `rtx_valid` is high with `rtx_first`/`rtx_last` on the cycle after expiry. A timeout value of 0 acts as 1.
- R5: Each pending request is shown for exactly one cycle. When several are pending, the lowest collection index goes first and the next one follows on the next cycle.
- R6: An acknowledgement is accepted only when it names the last frame of a collection whose frames have all been sent. An acknowledgement naming any other frame, or arriving before the collection is fully sent, has no effect.
- R7: A repeated acknowledgement for a collection that is already done has no effect.
- R8: An accepted acknowledgement stops that collection's timer and cancels any retransmission request for it that has not yet been shown.
- R9: `msg_done` is high exactly when every collection of the message is acknowledged. It stays high until the next `start`.
- R10: Collection size and frame count are captured at `start`. A size of 0 selects the default of 3 frames. A size above MAX_GRP is clamped to MAX_GRP, and a frame count above MAX_FRAMES is clamped to MAX_FRAMES.
- R11: A sent-frame report whose number is not below the message's frame count is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new message and capture its configuration |
| msg_frames | input | CW | Number of frames in the message |
| grp_size | input | GW | Frames per collection (0 selects default) |
| timeout_val | input | TW | Timer reload value in tick units |
| tick | input | 1 | Timebase pulse |
| sent_valid | input | 1 | A frame was placed on the wire |
| sent_frame | input | FW | Number of the frame sent |
| ack_valid | input | 1 | An acknowledgement arrived |
| ack_frame | input | FW | Frame number carried by the acknowledgement |
| rtx_valid | output | 1 | Retransmission request for one collection |
| rtx_first | output | FW | First frame to resend |
| rtx_last | output | FW | Last frame to resend |
| msg_done | output | 1 | All collections acknowledged |

## Verification
The bench sends frames out of order and keeps the last frame of a collection back for a long run of ticks. A design that started the timer on the first frame, or on the frame with the highest number, would request a retransmission too early. It makes three collections time out on the same tick and then acknowledges the third while the first is being shown. A design that got this wrong would reorder the requests or still show the cancelled one. It also checks a short final collection, a timeout value of 0, acknowledgements that name a non-last frame or arrive before the collection is fully sent, duplicate acknowledgements, and clamped configuration. Each of these would show up as a wrong frame range, a missing request, or a `msg_done` that rises early or falls.

// File: rtl/frx_pkg.sv
package frx_pkg;

  function automatic int unsigned coll_first(int unsigned idx, int unsigned gsz);
    return idx * gsz;
  endfunction

  function automatic int unsigned coll_last(int unsigned idx, int unsigned gsz,
                                            int unsigned nfr);
    int unsigned stop;
    stop = idx * gsz + gsz;
    if (stop > nfr) stop = nfr;
    return stop - 1;
  endfunction

  function automatic int unsigned eff_size(int unsigned req, int unsigned dflt,
                                           int unsigned mx);
    if (req == 0) return dflt;
    if (req > mx) return mx;
    return req;
  endfunction

  function automatic int unsigned clamp_cnt(int unsigned req, int unsigned mx);
    return (req > mx) ? mx : req;
  endfunction

endpackage

// File: rtl/frx_sent_map.sv
module frx_sent_map
  import frx_pkg::*;
#(
  parameter int MAX_FRAMES = 16,
  parameter int NCOL = MAX_FRAMES,
  parameter int FW = $clog2(MAX_FRAMES),
  parameter int CW = $clog2(MAX_FRAMES + 1),
  parameter int GW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            sent_valid,
  input  logic [FW-1:0]   sent_frame,
  input  logic [CW-1:0]   nfr,
  input  logic [GW-1:0]   gsz,
  output logic [NCOL-1:0] col_full,
  output logic [NCOL-1:0] col_live
);

  logic [MAX_FRAMES-1:0] sent_q;
  logic [MAX_FRAMES-1:0] sent_nx;
  logic                  in_range;

  assign in_range = 32'(sent_frame) < 32'(nfr);

  always_comb begin
    sent_nx = sent_q;
    if (sent_valid && in_range) sent_nx[sent_frame] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sent_q <= '0;
    else if (clear) sent_q <= '0;
    else            sent_q <= sent_nx;
  end

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [MAX_FRAMES-1:0] member;
    int unsigned lo, hi;
    assign lo = coll_first(c, 32'(gsz));
    assign hi = coll_last(c, 32'(gsz), 32'(nfr));
    for (genvar f = 0; f < MAX_FRAMES; f++) begin : g_bit
      assign member[f] = (f >= lo) && (f <= hi);
    end
    assign col_live[c] = lo < 32'(nfr);
    assign col_full[c] = col_live[c] && (&(sent_nx | ~member));
  end

endmodule

// File: rtl/frx_coll_timer.sv
module frx_coll_timer #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          full,
  input  logic          ack_match,
  input  logic          tick,
  input  logic          grant,
  input  logic [TW-1:0] tmo,
  output logic          armed,
  output logic          acked,
  output logic          pend,
  output logic          expire
);

  logic [TW-1:0] cnt;
  logic          ack_take, arm_now, running;

  assign ack_take = !clear && ack_match && armed && !acked;
  assign arm_now  = !clear && !armed && full;
  assign running  = armed && !acked;
  assign expire   = !clear && running && !ack_take && tick && (cnt <= TW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      armed <= 1'b0;
      acked <= 1'b0;
      pend  <= 1'b0;
      cnt   <= '0;
    end else if (ack_take) begin
      acked <= 1'b1;
      pend  <= 1'b0;
    end else if (arm_now) begin
      armed <= 1'b1;
      cnt   <= tmo;
    end else if (running) begin
      if (expire) begin
        pend <= 1'b1;
        cnt  <= tmo;
      end else begin
        if (grant) pend <= 1'b0;
        if (tick)  cnt  <= cnt - TW'(1);
      end
    end
  end

endmodule

// File: rtl/frx_rtx_arb.sv
module frx_rtx_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  assign grant = req & (~req + N'(1));
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/frx_tracker.sv
module frx_tracker
  import frx_pkg::*;
#(
  parameter int MAX_FRAMES = 16,
  parameter int MAX_GRP    = 8,
  parameter int DEF_GRP    = 3,
  parameter int TW         = 12,
  localparam int FW   = $clog2(MAX_FRAMES),
  localparam int CW   = $clog2(MAX_FRAMES + 1),
  localparam int GW   = $clog2(MAX_GRP + 1),
  localparam int NCOL = MAX_FRAMES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] msg_frames,
  input  logic [GW-1:0] grp_size,
  input  logic [TW-1:0] timeout_val,
  input  logic          tick,
  input  logic          sent_valid,
  input  logic [FW-1:0] sent_frame,
  input  logic          ack_valid,
  input  logic [FW-1:0] ack_frame,
  output logic          rtx_valid,
  output logic [FW-1:0] rtx_first,
  output logic [FW-1:0] rtx_last,
  output logic          msg_done
);

  logic [CW-1:0] nfr_q;
  logic [GW-1:0] gsz_q;
  logic          active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nfr_q    <= '0;
      gsz_q    <= GW'(DEF_GRP);
      active_q <= 1'b0;
    end else if (start) begin
      nfr_q    <= CW'(clamp_cnt(32'(msg_frames), MAX_FRAMES));
      gsz_q    <= GW'(eff_size(32'(grp_size), DEF_GRP, MAX_GRP));
      active_q <= 1'b1;
    end
  end

  // Named internal events for the checker
  logic [NCOL-1:0] st_full, st_live, st_armed, st_acked, st_pend;
  logic [NCOL-1:0] ev_expire, ev_grant;
  logic [FW-1:0]   col_first [NCOL];
  logic [FW-1:0]   col_last  [NCOL];
  logic [FW-1:0]   sel_idx;
  logic            any_pend;

  frx_sent_map #(
    .MAX_FRAMES(MAX_FRAMES), .NCOL(NCOL), .FW(FW), .CW(CW), .GW(GW)
  ) u_map (
    .clk(clk), .rst_n(rst_n), .clear(start),
    .sent_valid(sent_valid), .sent_frame(sent_frame),
    .nfr(nfr_q), .gsz(gsz_q),
    .col_full(st_full), .col_live(st_live)
  );

  for (genvar c = 0; c < NCOL; c++) begin : g_coll
    logic hit;
    assign col_first[c] = FW'(coll_first(c, 32'(gsz_q)));
    assign col_last[c]  = FW'(coll_last(c, 32'(gsz_q), 32'(nfr_q)));
    assign hit = ack_valid && st_live[c] && (ack_frame == col_last[c]);

    frx_coll_timer #(.TW(TW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .clear(start),
      .full(st_full[c]), .ack_match(hit), .tick(tick),
      .grant(ev_grant[c]), .tmo(timeout_val),
      .armed(st_armed[c]), .acked(st_acked[c]),
      .pend(st_pend[c]), .expire(ev_expire[c])
    );
  end

  frx_rtx_arb #(.N(NCOL), .IW(FW)) u_arb (
    .req(st_pend), .grant(ev_grant), .idx(sel_idx), .any(any_pend)
  );

  assign rtx_valid = any_pend;
  assign rtx_first = col_first[sel_idx];
  assign rtx_last  = col_last[sel_idx];
  assign msg_done  = active_q && (&(st_acked | ~st_live));

endmodule

// File: rtl/frx_tracker_chk.sv
module frx_tracker_chk #(
  parameter int NCOL = 16,
  parameter int CW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [CW-1:0]   msg_frames,
  input logic            rtx_valid,
  input logic            msg_done,
  input logic [NCOL-1:0] ev_expire,
  input logic [NCOL-1:0] ev_grant,
  input logic [NCOL-1:0] st_armed,
  input logic [NCOL-1:0] st_acked,
  input logic [NCOL-1:0] st_pend,
  input logic [NCOL-1:0] st_full
);

  logic seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  // R1: a fresh message begins with nothing pending and not done
  a_r1_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && msg_frames != '0) |=> (!rtx_valid && !msg_done));

  // R3: a timer only arms after its collection was completely sent
  a_r3_arm_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> ((st_armed & ~$past(st_armed) & ~$past(st_full)) == '0));

  // R4: an expiry is followed by a visible request
  a_r4_expire_shows: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_expire) |=> rtx_valid);

  // R5: at most one collection served per cycle
  a_r5_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_grant));

  // R8: an acknowledged collection never has a pending request
  a_r8_no_pend_when_acked: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_pend & st_acked) == '0));

  // R9: done holds until the next start
  a_r9_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && !start) |=> msg_done);

endmodule

bind frx_tracker frx_tracker_chk #(.NCOL(NCOL), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .msg_frames(msg_frames),
  .rtx_valid(rtx_valid), .msg_done(msg_done),
  .ev_expire(ev_expire), .ev_grant(ev_grant),
  .st_armed(st_armed), .st_acked(st_acked), .st_pend(st_pend),
  .st_full(st_full)
);

// File: tb/tb_frx_tracker.sv
`timescale 1ns/1ps
module tb_frx_tracker;

  localparam int MF = 16;
  localparam int MG = 8;
  localparam int TW = 12;
  localparam int FW = 4;
  localparam int CW = 5;
  localparam int GW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CW-1:0] msg_frames = '0;
  logic [GW-1:0] grp_size = '0;
  logic [TW-1:0] timeout_val = '0;
  logic tick = 1'b0;
  logic sent_valid = 1'b0;
  logic [FW-1:0] sent_frame = '0;
  logic ack_valid = 1'b0;
  logic [FW-1:0] ack_frame = '0;
  logic rtx_valid;
  logic [FW-1:0] rtx_first, rtx_last;
  logic msg_done;

  always #2.5 clk = ~clk;

  frx_tracker #(.MAX_FRAMES(MF), .MAX_GRP(MG), .DEF_GRP(3), .TW(TW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .msg_frames(msg_frames),
    .grp_size(grp_size), .timeout_val(timeout_val), .tick(tick),
    .sent_valid(sent_valid), .sent_frame(sent_frame),
    .ack_valid(ack_valid), .ack_frame(ack_frame),
    .rtx_valid(rtx_valid), .rtx_first(rtx_first), .rtx_last(rtx_last),
    .msg_done(msg_done)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  m_n = 0, m_g = 3;
  bit  m_act = 0;
  bit  m_sent [MF];
  bit  m_arm [MF], m_ack [MF], m_pend [MF];
  int  m_cnt [MF];

  function automatic int ncol();
    return (m_n + m_g - 1) / m_g;
  endfunction

  function automatic int lowest_pend();
    for (int c = 0; c < MF; c++) if (m_pend[c]) return c;
    return -1;
  endfunction

  task automatic m_clear();
    for (int i = 0; i < MF; i++) begin
      m_sent[i] = 0; m_arm[i] = 0; m_ack[i] = 0; m_pend[i] = 0; m_cnt[i] = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_clear(); m_n = 0; m_g = 3; m_act = 0;
    end else if (start) begin
      m_clear();
      m_n = (int'(msg_frames) > MF) ? MF : int'(msg_frames);
      m_g = (grp_size == 0) ? 3 : ((int'(grp_size) > MG) ? MG : int'(grp_size));
      m_act = 1;
    end else begin
      int gr;
      int t;
      gr = lowest_pend();
      t = int'(timeout_val);
      for (int c = 0; c < ncol(); c++) begin
        int lo, hi;
        bit full, hit;
        lo = c * m_g;
        hi = ((lo + m_g) < m_n ? (lo + m_g) : m_n) - 1;
        full = 1;
        for (int f = lo; f <= hi; f++)
          if (!(m_sent[f] || (sent_valid && int'(sent_frame) == f))) full = 0;
        hit = ack_valid && int'(ack_frame) == hi && m_arm[c] && !m_ack[c];
        if (hit) begin
          m_ack[c] = 1; m_pend[c] = 0;
        end else if (!m_arm[c] && full) begin
          m_arm[c] = 1; m_cnt[c] = t;
        end else if (m_arm[c] && !m_ack[c]) begin
          if (tick && m_cnt[c] <= 1) begin
            m_pend[c] = 1; m_cnt[c] = t;
          end else begin
            if (gr == c) m_pend[c] = 0;
            if (tick) m_cnt[c] = m_cnt[c] - 1;
          end
        end
      end
      if (sent_valid && int'(sent_frame) < m_n) m_sent[sent_frame] = 1;
    end
  end

  // Per-cycle comparison and request log
  int lg_f[$];
  int lg_l[$];

  always @(negedge clk) begin
    if (rst_n) begin
      int p;
      bit done_exp;
      p = lowest_pend();
      done_exp = m_act;
      for (int c = 0; c < ncol(); c++) if (!m_ack[c]) done_exp = 0;
      chk(rtx_valid == (p >= 0), "R4 rtx_valid", int'(rtx_valid), int'(p >= 0));
      if (p >= 0 && rtx_valid) begin
        int hi;
        hi = ((p * m_g + m_g) < m_n ? (p * m_g + m_g) : m_n) - 1;
        chk(int'(rtx_first) == p * m_g, "R5 rtx_first", int'(rtx_first), p * m_g);
        chk(int'(rtx_last) == hi, "R2 rtx_last", int'(rtx_last), hi);
      end
      chk(msg_done == done_exp, "R9 msg_done", int'(msg_done), int'(done_exp));
      if (rtx_valid) begin
        lg_f.push_back(int'(rtx_first));
        lg_l.push_back(int'(rtx_last));
      end
    end
  end

  // Stimulus helpers: each drives one cycle starting at a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start(input int n, input int g, input int t);
    start = 1; msg_frames = CW'(n); grp_size = GW'(g); timeout_val = TW'(t);
    @(negedge clk);
    start = 0;
  endtask

  task automatic send(input int f);
    sent_valid = 1; sent_frame = FW'(f);
    @(negedge clk);
    sent_valid = 0;
  endtask

  task automatic ack(input int f);
    ack_valid = 1; ack_frame = FW'(f);
    @(negedge clk);
    ack_valid = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic clr_log();
    lg_f.delete(); lg_l.delete();
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk(rtx_valid == 0, "R1 reset rtx", int'(rtx_valid), 0);
    chk(msg_done == 0, "R1 reset done", int'(msg_done), 0);
    rst_n = 1;
    idle(2);

    // Default size 3, seven frames: {0-2},{3-5},{6}
    do_start(7, 0, 5);
    chk(msg_done == 0, "R1 start clears done", int'(msg_done), 0);
    for (int f = 0; f < 7; f++) send(f);
    ack(2); ack(5);
    chk(msg_done == 0, "R9 not yet done", int'(msg_done), 0);
    ack(6);
    chk(msg_done == 1, "R10 default size 3 done", int'(msg_done), 1);

    // Out-of-order sending, timeout, short final collection
    do_start(8, 3, 3);
    chk(msg_done == 0, "R1 new message", int'(msg_done), 0);
    clr_log();
    send(2); send(0);
    ticks(5); idle(1);
    chk(lg_f.size() == 0, "R3 no rtx before full", lg_f.size(), 0);
    send(1);
    ticks(3); idle(1);
    chk(lg_f.size() == 1, "R4 one request", lg_f.size(), 1);
    if (lg_f.size() > 0) chk(lg_l[0] == 2, "R4 range last", lg_l[0], 2);
    clr_log();
    ack(1);
    ticks(3); idle(1);
    chk(lg_f.size() == 1, "R6 non-last ack ignored", lg_f.size(), 1);
    for (int f = 3; f < 8; f++) send(f);
    ack(2);
    clr_log();
    ticks(3); idle(2);
    chk(lg_l.size() == 2, "R2 two requests", lg_l.size(), 2);
    if (lg_l.size() == 2) begin
      chk(lg_f[1] == 6, "R2 short first", lg_f[1], 6);
      chk(lg_l[1] == 7, "R2 short last", lg_l[1], 7);
    end
    ack(5); ack(7);
    chk(msg_done == 1, "R9 all acked", int'(msg_done), 1);
    ack(7); idle(2);
    chk(msg_done == 1, "R7 duplicate ack", int'(msg_done), 1);

    // Simultaneous expiry, ordering and cancellation
    do_start(6, 2, 2);
    for (int f = 0; f < 6; f++) send(f);
    clr_log();
    ticks(2);
    ack(5);
    idle(3);
    chk(lg_f.size() == 2, "R8 cancelled request", lg_f.size(), 2);
    if (lg_f.size() == 2) begin
      chk(lg_f[0] == 0, "R5 lowest first", lg_f[0], 0);
      chk(lg_f[1] == 2, "R5 next", lg_f[1], 2);
    end
    ack(1); ack(3);
    chk(msg_done == 1, "R9 done after three", int'(msg_done), 1);
    clr_log();
    ack(3); ticks(4); idle(1);
    chk(lg_f.size() == 0 && msg_done, "R7 no effect", lg_f.size(), 0);

    // Timeout value 0 behaves as 1
    do_start(1, 1, 0);
    send(0);
    clr_log();
    ticks(1); idle(1);
    chk(lg_f.size() == 1, "R4 zero timeout", lg_f.size(), 1);
    ack(0);

    // Out-of-range frame ignored, default size
    do_start(4, 0, 2);
    send(10); send(0); send(1); send(2);
    clr_log();
    ticks(2); idle(1);
    chk(lg_f.size() == 1, "R11 only coll0", lg_f.size(), 1);
    send(3);
    ack(2); ack(3);
    chk(msg_done == 1, "R10 size3 split", int'(msg_done), 1);

    // Ack before collection fully sent is ignored
    do_start(3, 3, 2);
    send(0); send(1);
    ack(2);
    send(2);
    clr_log();
    ticks(2); idle(1);
    chk(lg_f.size() == 1, "R6 early ack ignored", lg_f.size(), 1);
    ack(2);
    chk(msg_done == 1, "R6 later ack accepted", int'(msg_done), 1);

    // Clamping of size and frame count
    do_start(20, 9, 4);
    for (int f = 0; f < 16; f++) send(f);
    ack(7);
    chk(msg_done == 0, "R10 half acked", int'(msg_done), 0);
    ack(15);
    chk(msg_done == 1, "R10 clamp done", int'(msg_done), 1);

    do_start(5, 2, 3);
    chk(msg_done == 0 && rtx_valid == 0, "R1 restart", int'(msg_done), 0);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule